// File: doc/BRIEF.md
# Voltage/Frequency Transition Sequencer with Thermal Fallback

This block moves a processor core from one voltage/frequency operating point to another. Software presents a target point (a 6-bit voltage code and a PLL frequency ratio) with a one-cycle request strobe. The sequencer steps the voltage code one value at a time toward the target, with a programmable settle dwell after each step. It asks the PLL to relock through a request/acknowledge handshake. The order of the two phases depends on the direction of the move. When the frequency rises, the voltage is raised first. When it falls, the PLL relocks first and the voltage drops afterwards. While a move is in flight, a hold output marks the core as unavailable and blocks snoops.

A thermal loop watches a die-hot input. When the die runs hot, the loop takes the sequencer over and moves the core to a configured low point. It then waits a fixed number of cycles. If the die has cooled by then, it restores the point that was in force before the fallback. If the die is still hot, it waits another period. Each fallback move and each restore move raises a one-cycle interrupt. A software request that arrives while a move or the thermal loop is active is kept and is started afterwards.

The voltage code counts downward in voltage: code 0 is the highest supply, each increment is 16 mV lower, and code 63 is 0.700 V.

Top module: `dvfs_sequencer`

## Requirements
- R1: After reset the voltage code equals RST_VID, the ratio equals RST_RATIO, and pll_req, core_hold and therm_irq are all low.
- R2: For a target ratio above the current ratio, the voltage code reaches the target code and has settled before ratio_out changes and pll_req rises.
- R3: For a target ratio below the current ratio, ratio_out takes the new value and pll_req rises in the cycle after acceptance. The voltage code starts to move only after pll_ack has been seen.
- R4: The voltage code changes by exactly one per step. Consecutive steps, and the last step and the next phase, are separated by step_dwell+1 cycles.
- R5: pll_req stays high until pll_ack is sampled high, and falls in the following cycle. The voltage code does not change while pll_req is high.
- R6: core_hold is high for the whole of every move and covers each voltage step and PLL handshake. It drops for at least one cycle between two consecutive moves.
- R7: A request equal to the current point causes no core_hold, no pll_req and no change of either output.
- R8: A request that arrives during a move is kept. A later request replaces an earlier waiting one, and the surviving request starts once the running move ends.
- R9: When die_hot is high and the sequencer is idle, the block moves to the point (lo_vid, lo_ratio) and pulses therm_irq for one cycle.
- R10: After the fallback move, the block waits HOLD_CYC+1 idle cycles. If die_hot is low at that point, it moves back to the point held before the fallback and pulses therm_irq. Otherwise it waits again.
- R11: Software requests made during a thermal episode are held until the restore move has completed, and are then carried out.
- R12: No single stretch of core_hold lasts longer than BUSY_MAX cycles (the switching-time bound), provided the PLL acknowledges promptly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe for a software target |
| req_vid | input | 6 | Target voltage code |
| req_ratio | input | RATIO_W | Target PLL ratio |
| step_dwell | input | DW | Settle cycles after each voltage step, minus one |
| lo_vid | input | 6 | Thermal fallback voltage code |
| lo_ratio | input | RATIO_W | Thermal fallback ratio |
| die_hot | input | 1 | Die temperature over limit |
| pll_ack | input | 1 | PLL reports lock on the new ratio |
| vid_out | output | 6 | Voltage code to the regulator |
| ratio_out | output | RATIO_W | Ratio to the PLL |
| pll_req | output | 1 | Relock request, held until pll_ack |
| core_hold | output | 1 | Core unavailable, snoops blocked |
| therm_irq | output | 1 | One-cycle pulse on each thermal move |

## Verification
The bench builds the block with a 5-bit ratio, HOLD_CYC of 12 instead of the default of thousands, and RST_VID 30 / RST_RATIO 8. This lets a whole thermal episode, including a second hold period while the die stays hot, fit in a few hundred cycles. Its PLL model acknowledges after a short fixed latency, so both orderings, the deferral of requests behind a running move and the restore followed by a held software request all occur in one run. Dwell values of 0, 1 and 2 check the step spacing at its tightest and with real settle waits.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
   localparam int VID_W = 6;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_VSTEP = 2'd1,
      SQ_PLL   = 2'd2
   } seq_st_t;

   typedef enum logic [1:0] {
      TH_COOL = 2'd0,
      TH_DOWN = 2'd1,
      TH_HOLD = 2'd2,
      TH_UP   = 2'd3
   } th_st_t;
endpackage

// File: rtl/dvfs_countdown.sv
module dvfs_countdown #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/dvfs_step_engine.sv
module dvfs_step_engine
   import dvfs_pkg::*;
#(
   parameter int                RATIO_W   = 8,
   parameter int                DW        = 4,
   parameter bit                STEP_ONE  = 1'b1,
   parameter logic [VID_W-1:0]  RST_VID   = 6'd30,
   parameter logic [RATIO_W-1:0] RST_RATIO = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [VID_W-1:0]   tgt_vid,
   input  logic [RATIO_W-1:0] tgt_ratio,
   input  logic [DW-1:0]      dwell,
   input  logic               pll_ack,
   output logic [VID_W-1:0]   vid,
   output logic [RATIO_W-1:0] ratio,
   output logic               pll_req,
   output logic               idle
);
   seq_st_t              st_q;
   logic [VID_W-1:0]     vid_q, tv_q, vid_nx;
   logic [RATIO_W-1:0]   ratio_q, tr_q;
   logic                 preq_q, pa_q;
   logic                 dz, ld;

   generate
      if (STEP_ONE) begin : g_single
         assign vid_nx = (tv_q > vid_q) ? vid_q + VID_W'(1) : vid_q - VID_W'(1);
      end else begin : g_jump
         assign vid_nx = tv_q;
      end
   endgenerate

   assign ld = (st_q == SQ_VSTEP) && dz && (vid_q != tv_q);

   dvfs_countdown #(.W(DW)) u_dwell (
      .clk(clk), .rst_n(rst_n), .load(ld), .val(dwell), .zero(dz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         vid_q   <= RST_VID;
         ratio_q <= RST_RATIO;
         preq_q  <= 1'b0;
         tv_q    <= RST_VID;
         tr_q    <= RST_RATIO;
         pa_q    <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (start && !(tgt_vid == vid_q && tgt_ratio == ratio_q)) begin
                  tv_q <= tgt_vid;
                  tr_q <= tgt_ratio;
                  if (tgt_ratio > ratio_q) begin
                     st_q <= SQ_VSTEP;
                     pa_q <= 1'b1;
                  end else if (tgt_ratio < ratio_q) begin
                     st_q    <= SQ_PLL;
                     ratio_q <= tgt_ratio;
                     preq_q  <= 1'b1;
                     pa_q    <= 1'b0;
                  end else begin
                     st_q <= SQ_VSTEP;
                     pa_q <= 1'b0;
                  end
               end
            end
            SQ_VSTEP: begin
               if (dz) begin
                  if (vid_q != tv_q) begin
                     vid_q <= vid_nx;
                  end else if (pa_q) begin
                     st_q    <= SQ_PLL;
                     ratio_q <= tr_q;
                     preq_q  <= 1'b1;
                     pa_q    <= 1'b0;
                  end else begin
                     st_q <= SQ_IDLE;
                  end
               end
            end
            SQ_PLL: begin
               if (pll_ack) begin
                  preq_q <= 1'b0;
                  st_q   <= (vid_q != tv_q) ? SQ_VSTEP : SQ_IDLE;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign vid     = vid_q;
   assign ratio   = ratio_q;
   assign pll_req = preq_q;
   assign idle    = (st_q == SQ_IDLE);
endmodule

// File: rtl/dvfs_thermal_loop.sv
module dvfs_thermal_loop
   import dvfs_pkg::*;
#(
   parameter int RATIO_W  = 8,
   parameter int HOLD_CYC = 4000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               die_hot,
   input  logic               seq_idle,
   input  logic [VID_W-1:0]   lo_vid,
   input  logic [RATIO_W-1:0] lo_ratio,
   input  logic [VID_W-1:0]   cur_vid,
   input  logic [RATIO_W-1:0] cur_ratio,
   output logic               th_start,
   output logic [VID_W-1:0]   th_vid,
   output logic [RATIO_W-1:0] th_ratio,
   output logic               th_cool,
   output logic               irq
);
   localparam int HW = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

   th_st_t               st_q, st_d;
   logic [VID_W-1:0]     home_v_q;
   logic [RATIO_W-1:0]   home_r_q;
   logic                 irq_q, hload, hz;

   dvfs_countdown #(.W(HW)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(hload), .val(HOLD_V), .zero(hz)
   );

   always_comb begin
      st_d     = st_q;
      th_start = 1'b0;
      th_vid   = lo_vid;
      th_ratio = lo_ratio;
      hload    = 1'b0;
      unique case (st_q)
         TH_COOL: if (die_hot && seq_idle) begin
            th_start = 1'b1;
            st_d     = TH_DOWN;
         end
         TH_DOWN: if (seq_idle) begin
            hload = 1'b1;
            st_d  = TH_HOLD;
         end
         TH_HOLD: if (hz) begin
            if (!die_hot) begin
               th_start = 1'b1;
               th_vid   = home_v_q;
               th_ratio = home_r_q;
               st_d     = TH_UP;
            end else begin
               hload = 1'b1;
            end
         end
         TH_UP: if (seq_idle) st_d = TH_COOL;
         default: st_d = TH_COOL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= TH_COOL;
         home_v_q <= '0;
         home_r_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         st_q  <= st_d;
         irq_q <= th_start;
         if (st_q == TH_COOL && th_start) begin
            home_v_q <= cur_vid;
            home_r_q <= cur_ratio;
         end
      end
   end

   assign th_cool = (st_q == TH_COOL);
   assign irq     = irq_q;
endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer
   import dvfs_pkg::*;
#(
   parameter int                 RATIO_W   = 8,
   parameter int                 DW        = 4,
   parameter int                 HOLD_CYC  = 4000,
   parameter int                 BUSY_MAX  = 1000,
   parameter bit                 STEP_ONE  = 1'b1,
   parameter logic [5:0]         RST_VID   = 6'd30,
   parameter logic [RATIO_W-1:0] RST_RATIO = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [5:0]         req_vid,
   input  logic [RATIO_W-1:0] req_ratio,
   input  logic [DW-1:0]      step_dwell,
   input  logic [5:0]         lo_vid,
   input  logic [RATIO_W-1:0] lo_ratio,
   input  logic               die_hot,
   input  logic               pll_ack,
   output logic [5:0]         vid_out,
   output logic [RATIO_W-1:0] ratio_out,
   output logic               pll_req,
   output logic               core_hold,
   output logic               therm_irq
);
   generate
      if (VID_W != 6) begin : g_bad_vid
         $error("voltage code must be 6 bits");
      end
      if (RATIO_W < 2) begin : g_bad_ratio
         $error("RATIO_W must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (BUSY_MAX < 8) begin : g_bad_busy
         $error("BUSY_MAX too small");
      end
   endgenerate

   logic               pend_q;
   logic [5:0]         pv_q;
   logic [RATIO_W-1:0] pr_q;
   logic               seq_idle, th_start, th_cool, sw_go, go;
   logic [5:0]         th_vid, go_vid;
   logic [RATIO_W-1:0] th_ratio, go_ratio;

   dvfs_thermal_loop #(.RATIO_W(RATIO_W), .HOLD_CYC(HOLD_CYC)) u_therm (
      .clk(clk), .rst_n(rst_n), .die_hot(die_hot), .seq_idle(seq_idle),
      .lo_vid(lo_vid), .lo_ratio(lo_ratio),
      .cur_vid(vid_out), .cur_ratio(ratio_out),
      .th_start(th_start), .th_vid(th_vid), .th_ratio(th_ratio),
      .th_cool(th_cool), .irq(therm_irq)
   );

   assign sw_go    = seq_idle && pend_q && th_cool && !th_start;
   assign go       = th_start || sw_go;
   assign go_vid   = th_start ? th_vid   : pv_q;
   assign go_ratio = th_start ? th_ratio : pr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pv_q   <= '0;
         pr_q   <= '0;
      end else if (req_valid) begin
         pend_q <= 1'b1;
         pv_q   <= req_vid;
         pr_q   <= req_ratio;
      end else if (sw_go) begin
         pend_q <= 1'b0;
      end
   end

   dvfs_step_engine #(
      .RATIO_W(RATIO_W), .DW(DW), .STEP_ONE(STEP_ONE),
      .RST_VID(RST_VID), .RST_RATIO(RST_RATIO)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .start(go),
      .tgt_vid(go_vid), .tgt_ratio(go_ratio), .dwell(step_dwell),
      .pll_ack(pll_ack), .vid(vid_out), .ratio(ratio_out),
      .pll_req(pll_req), .idle(seq_idle)
   );

   assign core_hold = !seq_idle;
endmodule

// File: rtl/dvfs_sequencer_chk.sv
module dvfs_sequencer_chk #(
   parameter int RATIO_W  = 8,
   parameter int BUSY_MAX = 1000,
   parameter bit STEP_ONE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [5:0]         vid_out,
   input logic [RATIO_W-1:0] ratio_out,
   input logic               pll_req,
   input logic               pll_ack,
   input logic               core_hold,
   input logic               therm_irq
);
   localparam int CW = $clog2(BUSY_MAX + 2);
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           run_q <= '0;
      else if (!core_hold)                  run_q <= '0;
      else if (run_q != CW'(BUSY_MAX + 1))  run_q <= run_q + CW'(1);
   end

   generate
      if (STEP_ONE) begin : g_step
         // R4
         single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vid_out != $past(vid_out) |->
               (vid_out == $past(vid_out) + 6'd1 || vid_out + 6'd1 == $past(vid_out)));
      end
   endgenerate

   // R5
   vid_still_in_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_req |-> $stable(vid_out));

   // R5
   req_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_req) |-> $past(pll_ack));

   // R6
   step_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vid_out != $past(vid_out) |-> $past(core_hold));

   // R6
   relock_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_req |-> core_hold);

   // R2
   ratio_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_out != $past(ratio_out) |-> (pll_req && !$past(pll_req)));

   // R9
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      therm_irq |=> !therm_irq);

   // R12
   hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_hold |-> run_q < CW'(BUSY_MAX));
endmodule

bind dvfs_sequencer dvfs_sequencer_chk #(
   .RATIO_W(RATIO_W), .BUSY_MAX(BUSY_MAX), .STEP_ONE(STEP_ONE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vid_out(vid_out), .ratio_out(ratio_out),
   .pll_req(pll_req), .pll_ack(pll_ack), .core_hold(core_hold),
   .therm_irq(therm_irq)
);

// File: tb/dvfs_sequencer_test.sv
module dvfs_sequencer_test;
   localparam int RW = 5, DWT = 4, HOLD = 12, BMAX = 1000, LAT = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, die_hot = 1'b0, pll_ack = 1'b0;
   logic [5:0] req_vid = '0, lo_vid = 6'd40;
   logic [RW-1:0] req_ratio = '0, lo_ratio = 5'd4;
   logic [DWT-1:0] step_dwell = '0;
   logic [5:0] vid_out;
   logic [RW-1:0] ratio_out;
   logic pll_req, core_hold, therm_irq;

   dvfs_sequencer #(.RATIO_W(RW), .DW(DWT), .HOLD_CYC(HOLD), .BUSY_MAX(BMAX),
      .STEP_ONE(1'b1), .RST_VID(6'd30), .RST_RATIO(5'd8)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vid(req_vid),
      .req_ratio(req_ratio), .step_dwell(step_dwell), .lo_vid(lo_vid),
      .lo_ratio(lo_ratio), .die_hot(die_hot), .pll_ack(pll_ack),
      .vid_out(vid_out), .ratio_out(ratio_out), .pll_req(pll_req),
      .core_hold(core_hold), .therm_irq(therm_irq));

   always #10 clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // PLL responder: acknowledges LAT cycles after a request is seen
   int lc = 0;
   always @(posedge clk) begin
      if (pll_req && !pll_ack) begin
         lc++;
         if (lc >= LAT) begin pll_ack <= 1'b1; lc = 0; end
      end else pll_ack <= 1'b0;
   end

   // behavioural reference model, advanced on each rising edge
   int mv, mr, mpq, ms, mtv, mtr, mpa, mdc, mpend, mpv, mpr;
   int mth, mhc, mhv, mhr, mirq;
   always @(posedge clk) begin
      if (!rst_n) begin
         mv = 30; mr = 8; mpq = 0; ms = 0; mtv = 30; mtr = 8; mpa = 0; mdc = 0;
         mpend = 0; mpv = 0; mpr = 0; mth = 0; mhc = 0; mhv = 0; mhr = 0; mirq = 0;
      end else begin
         int ts, tv, tr, nth, nhc, ndc, sv, sr;
         bit idle, go, st;
         idle = (ms == 0);
         ts = 0; tv = lo_vid; tr = lo_ratio; nth = mth;
         nhc = (mhc > 0) ? mhc - 1 : 0;
         if (mth == 0) begin
            if (die_hot && idle) begin ts = 1; nth = 1; mhv = mv; mhr = mr; end
         end else if (mth == 1) begin
            if (idle) begin nth = 2; nhc = HOLD; end
         end else if (mth == 2) begin
            if (mhc == 0) begin
               if (!die_hot) begin ts = 1; tv = mhv; tr = mhr; nth = 3; end
               else nhc = HOLD;
            end
         end else if (idle) nth = 0;
         go = idle && mpend != 0 && mth == 0 && ts == 0;
         st = (ts != 0) || go;
         sv = (ts != 0) ? tv : mpv;
         sr = (ts != 0) ? tr : mpr;
         if (req_valid) begin mpend = 1; mpv = req_vid; mpr = req_ratio; end
         else if (go) mpend = 0;
         ndc = (mdc > 0) ? mdc - 1 : 0;
         if (ms == 0) begin
            if (st && !(sv == mv && sr == mr)) begin
               mtv = sv; mtr = sr;
               if (sr > mr) begin ms = 1; mpa = 1; end
               else if (sr < mr) begin ms = 2; mr = sr; mpq = 1; mpa = 0; end
               else begin ms = 1; mpa = 0; end
            end
         end else if (ms == 1) begin
            if (mdc == 0) begin
               if (mv != mtv) begin mv = (mtv > mv) ? mv + 1 : mv - 1; ndc = step_dwell; end
               else if (mpa != 0) begin ms = 2; mr = mtr; mpq = 1; mpa = 0; end
               else ms = 0;
            end
         end else begin
            if (pll_ack) begin mpq = 0; ms = (mv != mtv) ? 1 : 0; end
         end
         mdc = ndc; mth = nth; mhc = nhc; mirq = ts;
      end
   end

   // lock-step comparison and monitors on the falling edge
   int cyc = 0, rises = 0, irqs = 0, run = 0, max_run = 0;
   int prev_v = 30, prev_r = 8, last_vchg = 0, min_gap = 1000;
   int vid_at_rup = -1, ratio_at_vchg = -1;
   int done_prev_v = -1, done_prev_r = -1, done_last_v = -1, done_last_r = -1;
   bit prev_busy = 0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(vid_out == 6'(mv), "R4 vid model", vid_out, mv);
         chk(ratio_out == RW'(mr), "R2 ratio model", ratio_out, mr);
         chk(pll_req == (mpq != 0), "R5 pll_req model", pll_req, mpq);
         chk(core_hold == (ms != 0), "R6 core_hold model", core_hold, ms != 0);
         chk(therm_irq == (mirq != 0), "R9 irq model", therm_irq, mirq);
         if (int'(vid_out) != prev_v) begin
            if (cyc - last_vchg < min_gap) min_gap = cyc - last_vchg;
            last_vchg = cyc;
            ratio_at_vchg = ratio_out;
         end
         if (int'(ratio_out) > prev_r) vid_at_rup = vid_out;
         if (core_hold && !prev_busy) rises++;
         if (!core_hold && prev_busy) begin
            done_prev_v = done_last_v; done_prev_r = done_last_r;
            done_last_v = vid_out; done_last_r = ratio_out;
         end
         if (therm_irq) irqs++;
         run = core_hold ? run + 1 : 0;
         if (run > max_run) max_run = run;
      end
      prev_v = vid_out; prev_r = ratio_out; prev_busy = core_hold;
   end

   task automatic request(input int v, input int r);
      @(negedge clk);
      req_valid = 1'b1; req_vid = 6'(v); req_ratio = RW'(r);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic settle();
      int quiet = 0;
      for (int i = 0; i < 3000 && quiet < 4; i++) begin
         @(negedge clk);
         quiet = core_hold ? 0 : quiet + 1;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(vid_out == 6'd30, "R1 vid", vid_out, 30);
      chk(ratio_out == 5'd8, "R1 ratio", ratio_out, 8);
      chk(!pll_req && !core_hold && !therm_irq, "R1 outputs low",
          {pll_req, core_hold, therm_irq}, 0);
      rst_n = 1'b1;

      // upward move with dwell 2
      step_dwell = 4'd2; min_gap = 1000; last_vchg = cyc;
      request(24, 12); settle();
      chk(vid_out == 6'd24 && ratio_out == 5'd12, "R2 final point", vid_out, 24);
      chk(vid_at_rup == 24, "R2 voltage before relock", vid_at_rup, 24);
      chk(min_gap == 3, "R4 step spacing dwell 2", min_gap, 3);

      // downward move
      request(34, 6); settle();
      chk(vid_out == 6'd34 && ratio_out == 5'd6, "R3 final point", vid_out, 34);
      chk(ratio_at_vchg == 6, "R3 relock before voltage", ratio_at_vchg, 6);

      // no-op request
      rises = 0;
      request(34, 6); repeat (10) @(negedge clk);
      chk(rises == 0, "R7 no hold on equal target", rises, 0);
      chk(vid_out == 6'd34 && ratio_out == 5'd6, "R7 point unchanged", vid_out, 34);

      // deferral: second request replaced by third
      step_dwell = 4'd1; rises = 0;
      request(28, 10); repeat (3) @(negedge clk);
      request(26, 11); request(32, 7); settle();
      chk(vid_out == 6'd32 && ratio_out == 5'd7, "R8 latest deferred request", vid_out, 32);
      chk(rises == 2, "R6 hold drops between moves", rises, 2);

      // voltage-only move with dwell 0
      step_dwell = 4'd0; min_gap = 1000; last_vchg = cyc;
      request(30, 7); settle();
      chk(vid_out == 6'd30 && ratio_out == 5'd7, "R4 voltage-only move", vid_out, 30);
      chk(min_gap == 1, "R4 step spacing dwell 0", min_gap, 1);

      // thermal episode
      irqs = 0;
      @(negedge clk); die_hot = 1'b1;
      repeat (60) @(negedge clk);
      chk(vid_out == 6'd40 && ratio_out == 5'd4, "R9 fallback point", vid_out, 40);
      chk(irqs == 1, "R9 one irq on fallback", irqs, 1);
      repeat (40) @(negedge clk);
      chk(irqs == 1 && vid_out == 6'd40, "R10 stays low while hot", irqs, 1);
      request(36, 9); repeat (20) @(negedge clk);
      chk(vid_out == 6'd40 && ratio_out == 5'd4, "R11 request held while hot", vid_out, 40);
      @(negedge clk); die_hot = 1'b0;
      repeat (40) @(negedge clk);
      settle();
      chk(irqs == 2, "R10 irq on restore", irqs, 2);
      chk(done_prev_v == 30 && done_prev_r == 7, "R10 restored prior point", done_prev_v, 30);
      chk(vid_out == 6'd36 && ratio_out == 5'd9, "R11 held request carried out", vid_out, 36);
      chk(max_run < BMAX, "R12 hold stretch bound", max_run, BMAX);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule